// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits in front of a processor interrupt controller and conditions nine external interrupt pins. One pin is non-maskable, and eight pins (IRQ0 to IRQ7) are maskable. Each pin passes through a synchronizer. The block then turns it into a request in one of two ways. It either follows the pin level, or it latches an edge in a pending flag that software later clears.

Software sets the detection mode through three registers on a small register bus. The bus has a 2-bit address, a write strobe, 16-bit write data and combinational read data. A control register holds the NMI edge polarity and one sense select per IRQ, and it also shows the live NMI pin level. A direction register holds one 2-bit edge-direction field per IRQ. A pending register shows the latched flags, and writing 1 to a bit clears that flag. When software changes the mode of an input, any flag pending for that input is dropped. Arbitration between requests, vector generation and acknowledge sequencing are done elsewhere.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all three registers read 0, apart from the NMI level bit, and every request output is inactive while all pins are held high. Address 3 always reads 0.
- R2: Bit 15 of the control register (address 0) and the `nmi_level` output both show the synchronized NMI pin level (1 = high). Writes to bit 15 have no effect.
- R3: Control register bits 14 to 9 always read 0, whatever value is written to them.
- R4: Control bit 8 sets the NMI polarity: 0 detects a falling edge and 1 detects a rising edge. A detected NMI edge sets a flag, and `nmi_req` stays high until that flag is cleared.
- R5: Control bit (7 − n) is the sense select of IRQn. When it is 0, `irq_req[n]` is high exactly while the synchronized pin is low, and no flag is latched.
- R6: When the sense select of IRQn is 1, the field at bits [2n+1:2n] of the direction register (address 1) picks the edge. 00 means falling, 01 rising, 10 both edges, and 11 is treated as falling. A detected edge latches a flag that drives `irq_req[n]`.
- R7: The pending register (address 2) shows the IRQn flag at bit n and the NMI flag at bit 8. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R8: If an edge is detected in the same cycle as a write of 1 that clears the same flag, the flag stays set.
- R9: A register write that changes the NMI polarity, an IRQn sense select or an IRQn direction field clears that input's flag. A write that leaves the mode unchanged keeps the flag.
- R10: Each pin passes through two flops. `nmi_level` and a level-sensed request change on the 2nd rising clock edge after the pin changes. An edge request appears on the 3rd rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| irq_pin | input | 8 | Maskable interrupt pins; bit n is IRQn |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| nmi_level | output | 1 | Synchronized NMI pin level |
| nmi_req | output | 1 | Non-maskable request |
| irq_req | output | 8 | Maskable requests; bit n is IRQn |

## Verification
Two events can reach a flag in the same clock cycle: a newly detected edge that sets it, and a clear request that removes it. The clear can be a write of 1 to the pending register, or a write that changes the input's mode. For the first case, the bench times a pin edge so that its set lands on the same edge as a write of 1 to the pending bit. It then expects the flag to still read as set. For the second case, it changes a direction field while a flag is pending and expects the flag to be gone. Writing back an unchanged field must leave the flag in place.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PEND = 2'd2;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_dir_e;
endpackage

// File: rtl/eirq_sync.sv
// Two-flop synchronizer plus a history flop for edge detection.
// All stages reset to 1: the pins are idle high.
module eirq_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur  = s2_q;
  assign prev = s3_q;
endmodule

// File: rtl/eirq_chan.sv
// One input channel: edge detection, pending flag, request select.
module eirq_chan
  import eirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur,
  input  logic       prev,
  input  logic       level_sel,
  input  logic [1:0] dir,
  input  logic       flush,
  input  logic       clr,
  output logic       flag,
  output logic       req
);
  logic fall, rise, hit;
  logic flag_q, flag_d, flag_en;

  assign fall = prev & ~cur;
  assign rise = ~prev & cur;

  always_comb begin
    case (edge_dir_e'(dir))
      EDGE_RISE: hit = rise;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = fall;
    endcase
  end

  // Priority: mode flush, then a new edge, then a software clear.
  always_comb begin
    flag_en = flush | (hit & ~level_sel) | clr;
    if (flush)
      flag_d = 1'b0;
    else if (hit && !level_sel)
      flag_d = 1'b1;
    else
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (flag_en)
      flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign req  = level_sel ? ~cur : flag_q;
endmodule

// File: rtl/eirq_regs.sv
// Control, direction and pending-clear decode.
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic                   nmi_pol,
  output logic [N_IRQ-1:0]       sense_q,
  output logic [2*N_IRQ-1:0]     dir_q,
  output logic [N_IRQ-1:0]       level_sel,
  output logic [N_IRQ:0]         flush,
  output logic [N_IRQ:0]         clr
);
  localparam int NMI_BIT = N_IRQ;

  logic wr_ctrl, wr_dir, wr_pend;
  logic nmi_pol_q;
  logic [N_IRQ-1:0]   sense_d;
  logic [2*N_IRQ-1:0] dir_d;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_dir  = wr && (addr == A_DIR);
  assign wr_pend = wr && (addr == A_PEND);

  assign sense_d = wdata[N_IRQ-1:0];
  assign dir_d   = wdata[2*N_IRQ-1:0];

  always_comb begin
    flush = '0;
    clr   = '0;
    if (wr_ctrl)
      flush[NMI_BIT] = wdata[NMI_BIT] != nmi_pol_q;
    for (int i = 0; i < N_IRQ; i++) begin
      if (wr_ctrl && (sense_d[N_IRQ-1-i] != sense_q[N_IRQ-1-i]))
        flush[i] = 1'b1;
      if (wr_dir && (dir_d[2*i +: 2] != dir_q[2*i +: 2]))
        flush[i] = 1'b1;
    end
    if (wr_pend)
      clr = wdata[N_IRQ:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pol_q <= 1'b0;
      sense_q   <= '0;
    end else if (wr_ctrl) begin
      nmi_pol_q <= wdata[NMI_BIT];
      sense_q   <= sense_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dir_q <= '0;
    else if (wr_dir)
      dir_q <= dir_d;
  end

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_lvl
      assign level_sel[g] = ~sense_q[N_IRQ-1-g];
    end
  endgenerate

  assign nmi_pol = nmi_pol_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eirq_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   nmi_pin,
  input  logic [N_IRQ-1:0]       irq_pin,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic                   nmi_level,
  output logic                   nmi_req,
  output logic [N_IRQ-1:0]       irq_req
);
  localparam int N_IN = N_IRQ + 1;

  logic rst_s1_q, rst_s2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i = rst_s2_q;

  logic [N_IN-1:0] cur, prev, flags, flush, clr, chan_req, chan_lvl;
  logic [1:0]      chan_dir [N_IN];
  logic            nmi_pol;
  logic [N_IRQ-1:0]   sense_q, level_sel;
  logic [2*N_IRQ-1:0] dir_q;

  eirq_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_i), .pin({nmi_pin, irq_pin}),
    .cur(cur), .prev(prev)
  );

  eirq_regs #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .nmi_pol(nmi_pol), .sense_q(sense_q), .dir_q(dir_q),
    .level_sel(level_sel), .flush(flush), .clr(clr)
  );

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_ch
      if (g == N_IRQ) begin : g_nmi
        assign chan_lvl[g] = 1'b0;
        assign chan_dir[g] = {1'b0, nmi_pol};
      end else begin : g_irq
        assign chan_lvl[g] = level_sel[g];
        assign chan_dir[g] = dir_q[2*g +: 2];
      end
      eirq_chan u_chan (
        .clk(clk), .rst_n(rst_i), .cur(cur[g]), .prev(prev[g]),
        .level_sel(chan_lvl[g]), .dir(chan_dir[g]),
        .flush(flush[g]), .clr(clr[g]),
        .flag(flags[g]), .req(chan_req[g])
      );
    end
  endgenerate

  assign nmi_level = cur[N_IRQ];
  assign nmi_req   = chan_req[N_IRQ];
  assign irq_req   = chan_req[N_IRQ-1:0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[DATA_W-1]  = nmi_level;
        reg_rdata[N_IRQ]     = nmi_pol;
        reg_rdata[N_IRQ-1:0] = sense_q;
      end
      A_DIR:   reg_rdata[2*N_IRQ-1:0] = dir_q;
      A_PEND:  reg_rdata[N_IRQ:0]     = flags;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_pin,
  input logic             nmi_level,
  input logic             nmi_req,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic [15:0]      reg_rdata,
  input logic [N_IRQ:0]   flags,
  input logic [N_IRQ-1:0] level_sel
);
  logic [2:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cyc_q <= '0;
    else if (cyc_q != 3'd7)
      cyc_q <= cyc_q + 3'd1;
  end

  // R2 / R10: level readback is the pin two clocks late
  assert_nmi_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 3'd5) |-> (nmi_level == $past(nmi_pin, 2)));

  // R3: reserved bits read as zero
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[14:9] == 6'd0));

  // R4: an NMI request only rises after the synchronized level moved
  assert_nmi_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> ($past(nmi_level) != $past(nmi_level, 2)));

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_a
      // R5: a level-sensed input never holds a latched flag
      assert_level_noflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        level_sel[g] |-> !flags[g]);
      // R7: without a register write a pending flag holds
      assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[g] && !reg_wr) |=> flags[g]);
    end
  endgenerate
endmodule

bind ext_irq_sense eirq_checker #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .nmi_level(nmi_level),
  .nmi_req(nmi_req), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .flags(flags), .level_sel(level_sel)
);

// File: tb/ext_irq_sense_test.sv
`timescale 1ns/1ps
module ext_irq_sense_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pin = 1'b1;
  logic [7:0]  irq_pin = 8'hFF;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        nmi_level, nmi_req;
  logic [7:0]  irq_req;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  ext_irq_sense uut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nmi_level(nmi_level), .nmi_req(nmi_req),
    .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // let a pin change settle through sync and edge logic, then sample at negedge
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); chk("R1 ctrl", d, 16'h8000);
    rd(2'd1, d); chk("R1 dir", d, 16'h0000);
    rd(2'd2, d); chk("R1 pend", d, 16'h0000);
    rd(2'd3, d); chk("R1 addr3", d, 16'h0000);
    chk("R1 reqs", {7'd0, nmi_req, irq_req}, 16'h0000);
  endtask

  task automatic t_ctrl_bits();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R3 reserved read 0", d, 16'h81FF);
    wr(2'd0, 16'h0000);
    rd(2'd0, d); chk("R2 level bit not writable", d, 16'h8000);
  endtask

  task automatic t_nmi_fall();
    logic [15:0] d;
    @(negedge clk); nmi_pin = 1'b0;
    settle();
    chk("R2 nmi_level low", {15'd0, nmi_level}, 16'd0);
    chk("R4 falling nmi req", {15'd0, nmi_req}, 16'd1);
    rd(2'd0, d); chk("R2 ctrl bit15 low", d, 16'h0000);
    wr(2'd0, 16'h8000);
    rd(2'd0, d); chk("R2 write bit15 ignored", d, 16'h0000);
    rd(2'd2, d); chk("R7 nmi pending bit8", d, 16'h0100);
    wr(2'd2, 16'h0100);
    chk("R7 nmi cleared", {15'd0, nmi_req}, 16'd0);
    @(negedge clk); nmi_pin = 1'b1;
    settle();
    chk("R4 rising ignored in falling mode", {15'd0, nmi_req}, 16'd0);
  endtask

  task automatic t_nmi_rise();
    wr(2'd0, 16'h0100);
    @(negedge clk); nmi_pin = 1'b0;
    settle();
    chk("R4 falling ignored in rising mode", {15'd0, nmi_req}, 16'd0);
    @(negedge clk); nmi_pin = 1'b1;
    settle();
    chk("R4 rising nmi req", {15'd0, nmi_req}, 16'd1);
    wr(2'd2, 16'h0100);
    chk("R4 nmi req cleared", {15'd0, nmi_req}, 16'd0);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_level();
    logic [15:0] d;
    @(negedge clk); irq_pin[3] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 level not yet after 1 edge", {8'd0, irq_req}, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R5 R10 level req after 2 edges", {8'd0, irq_req}, 16'h0008);
    rd(2'd2, d); chk("R5 no latch in level mode", d, 16'h0000);
    @(negedge clk); irq_pin[3] = 1'b1;
    settle();
    chk("R5 level release", {8'd0, irq_req}, 16'h0000);
  endtask

  task automatic t_edge_modes();
    logic [15:0] d;
    logic [1:0] fall_exp, rise_exp;
    wr(2'd0, 16'h0040);              // IRQ1 edge-sensed (ctrl bit 6)
    for (int m = 0; m < 4; m++) begin
      fall_exp = (m == 1) ? 2'b00 : 2'b10;
      rise_exp = (m == 1 || m == 2) ? 2'b10 : 2'b00;
      wr(2'd1, 16'(m) << 2);
      @(negedge clk); irq_pin[1] = 1'b0;
      settle();
      chk($sformatf("R6 mode %0d falling req", m), {8'd0, irq_req}, {14'd0, fall_exp});
      rd(2'd2, d); chk($sformatf("R6 mode %0d falling pend", m), d, {14'd0, fall_exp});
      wr(2'd2, 16'h0002);
      @(negedge clk); irq_pin[1] = 1'b1;
      settle();
      chk($sformatf("R6 mode %0d rising req", m), {8'd0, irq_req}, {14'd0, rise_exp});
      wr(2'd2, 16'h0002);
    end
  endtask

  task automatic t_w1c_zero();
    logic [15:0] d;
    wr(2'd1, 16'h0008);              // IRQ1 both edges
    @(negedge clk); irq_pin[1] = 1'b0;
    settle();
    wr(2'd2, 16'h0000);
    rd(2'd2, d); chk("R7 write 0 keeps flag", d, 16'h0002);
    wr(2'd2, 16'h00FD);
    rd(2'd2, d); chk("R7 other bits leave flag", d, 16'h0002);
    // flag still set: rising edge set coincides with clear write
    @(negedge clk); irq_pin[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 2'd2; reg_wdata = 16'h0002; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(2'd2, d); chk("R8 set wins over clear", d, 16'h0002);
    wr(2'd2, 16'h0002);
    rd(2'd2, d); chk("R7 cleared by 1", d, 16'h0000);
  endtask

  task automatic t_flush();
    logic [15:0] d;
    wr(2'd0, 16'h0060);              // IRQ1 and IRQ2 edge-sensed
    wr(2'd1, 16'h0008);              // IRQ1 both, IRQ2 falling
    @(negedge clk); irq_pin[2] = 1'b0;
    settle();
    rd(2'd2, d); chk("R6 irq2 pending", d, 16'h0004);
    wr(2'd1, 16'h0008);
    rd(2'd2, d); chk("R9 same mode keeps flag", d, 16'h0004);
    wr(2'd0, 16'h0160);              // NMI polarity change only
    rd(2'd2, d); chk("R9 other input change keeps flag", d, 16'h0004);
    wr(2'd1, 16'h0018);              // IRQ2 to rising
    rd(2'd2, d); chk("R9 mode change flushes", d, 16'h0000);
    chk("R9 req dropped", {8'd0, irq_req}, 16'h0000);
    @(negedge clk); irq_pin[2] = 1'b1;
    settle();
    rd(2'd2, d); chk("R6 irq2 rising after change", d, 16'h0004);
    wr(2'd0, 16'h0000);
    rd(2'd2, d); chk("R9 sense change flushes", d, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(posedge clk);
    t_reset();
    t_ctrl_bits();
    t_nmi_fall();
    t_nmi_rise();
    t_level();
    t_edge_modes();
    t_w1c_zero();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule